// File: doc/BRIEF.md
# AUX Channel Transaction Register Front-End

This block is the software-facing register file of a display auxiliary-channel master. Software fills in a target address, a command, a length and up to sixteen payload bytes. It then sets a request bit. The block presents that request to a serial transaction engine for exactly one cycle on a start strobe, then waits for the engine's done strobe. While it waits, the request bit stays set and reads back as a busy indication.

When the engine reports completion, the block stores several results:
- the reply type;
- the received byte count, for acknowledged reads only;
- the accumulated error flags;
- the received payload.

Completion also raises a pending interrupt. Transitions of the hot-plug-detect level and sink interrupt pulses raise pending interrupts of their own. One level-sensitive interrupt output combines all pending interrupts that are enabled.

All registers are 32 bits wide and word-addressed: register index k sits at byte offset 4*k. An access to an offset that is not a multiple of four is ignored. Payload bytes are packed little-endian, so message byte n lives in buffer word n/4 at bit 8*(n mod 4).

Top module: `auxch_regfront`

## Requirements
- R1: After reset, every register reads as zero (hot-plug bit aside), `irq_o` is 0 and `eng_start` is 0.
- R2: The register map (by index) is:
  - index 0: address register, low 20 bits, read/write;
  - index 3: interrupt enable, low 4 bits, read/write;
  - indices 8 to 11: transmit words 0 to 3, read/write;
  - indices 12 to 15: receive words 0 to 3, read-only.
- R3: Transmit byte n appears on `eng_txdata[8n+7:8n]`, and word w of the buffer is held at bits 32w+31:32w. `eng_len` is the length field plus one. When the address-only bit is set, `eng_len` is 0 and `eng_addr_only` is 1.
- R4: The control register (index 1) has these fields:
  - bits 3:0: length minus one;
  - bit 8: address-only;
  - bits 14:12: command (0 I2C write, 1 I2C read, 2 I2C status-update, 3 native write, 4 I2C write with middle-of-transaction, 5 I2C read with middle-of-transaction, 6 I2C status-update with middle-of-transaction, 7 native read);
  - bit 16: request.

  Writing bit 16 as 1 while idle raises `eng_start` for exactly the next cycle, with the command and address on the engine outputs.
- R5: The request bit reads back as 1 from the start until the cycle in which `eng_done` is seen. At that clock edge it clears.
- R6: While the request bit is set, writes to the control register and to the transmit words have no effect.
- R7: Each completion captures the following:
  - `eng_reply` goes into status bits 18:16 (0 ACK, 1 NACK, 2 DEFER, 4 I2C NACK, 5 I2C DEFER).
  - `eng_rxcnt` goes into status bits 4:0, and `eng_rxdata` into the receive words, only when the command is a read (1, 5, 7) and the reply is ACK. Otherwise the count becomes 0 and the receive words are kept.
- R8: Status bits 11:8 (timeout, receive error, sink-status error, missing stop) are set by `eng_err` at each completion. They stay set until status is written with a 1 in that bit position. Writing 0 there has no effect.
- R9: Status bit 28 shows the live `hpd` level.
- R10: The pending register (index 4) has these bits:
  - bit 0: done;
  - bit 1: `sink_irq`;
  - bit 2: `hpd` falling edge;
  - bit 3: `hpd` rising edge.

  Each bit is set regardless of its enable and is cleared by writing 1 to it. A set in the same cycle as a clear wins.
- R11: `irq_o` is 1 exactly when some pending bit and its enable bit are both 1. It is driven from register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_cmd | output | 3 | Command code |
| eng_addr_only | output | 1 | Address-only request |
| eng_addr | output | 20 | Target address |
| eng_len | output | 5 | Payload byte count |
| eng_txdata | output | 128 | Transmit payload |
| eng_done | input | 1 | Engine completion strobe |
| eng_reply | input | 3 | Reply type code |
| eng_rxcnt | input | 5 | Reply byte count |
| eng_err | input | 4 | Error flags for this transaction |
| eng_rxdata | input | 128 | Received payload |
| hpd | input | 1 | Hot-plug-detect level, already synchronous |
| sink_irq | input | 1 | Sink interrupt event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a register value is due at the falling edge right after the rising edge that wrote it. Every check samples there or later, one nanosecond after driving the address.

Timing of each result, with each stimulus driven at a falling edge:
- The start strobe comes from one register after the control write. It is therefore checked high at the falling edge one cycle after the write is driven, and low one cycle later.
- Completion results, pending bits and `irq_o` all move at the rising edge that samples `eng_done`, `hpd` or `sink_irq`. They are read at the following falling edge.
- The simultaneous set-and-clear case drives both stimuli in the same cycle and reads the pending bit one edge later.

// File: rtl/auxch_pkg.sv
package auxch_pkg;
    localparam int WORD_W    = 32;
    localparam int BUF_WORDS = 4;
    localparam int BUF_BYTES = BUF_WORDS * 4;
    localparam int LEN_W     = $clog2(BUF_BYTES);
    localparam int CNT_W     = LEN_W + 1;
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam int NUM_IRQ   = 4;
    localparam int ERR_W     = 4;

    // register indices (word granularity)
    localparam int IDX_ADDR  = 0;
    localparam int IDX_CTRL  = 1;
    localparam int IDX_STAT  = 2;
    localparam int IDX_IEN   = 3;
    localparam int IDX_IPEND = 4;
    localparam int IDX_TX0   = 8;
    localparam int IDX_RX0   = 12;

    // control / status field positions
    localparam int CTRL_AO_BIT  = 8;
    localparam int CTRL_CMD_LSB = 12;
    localparam int CTRL_GO_BIT  = 16;
    localparam int STAT_ERR_LSB = 8;
    localparam int STAT_RPL_LSB = 16;
    localparam int STAT_HPD_BIT = 28;

    // interrupt source positions
    localparam int IRQ_DONE   = 0;
    localparam int IRQ_SINK   = 1;
    localparam int IRQ_UNPLUG = 2;
    localparam int IRQ_PLUG   = 3;

    typedef enum logic [2:0] {
        CMD_I2C_WR  = 3'd0,
        CMD_I2C_RD  = 3'd1,
        CMD_I2C_WSU = 3'd2,
        CMD_NAT_WR  = 3'd3,
        CMD_MOT_WR  = 3'd4,
        CMD_MOT_RD  = 3'd5,
        CMD_MOT_WSU = 3'd6,
        CMD_NAT_RD  = 3'd7
    } aux_cmd_e;

    localparam logic [2:0] RPL_ACK = 3'd0;

    typedef struct packed {
        logic             go;
        aux_cmd_e         cmd;
        logic             addr_only;
        logic [LEN_W-1:0] len_m1;
    } ctrl_t;

    function automatic logic cmd_is_read(aux_cmd_e c);
        return (c == CMD_I2C_RD) || (c == CMD_MOT_RD) || (c == CMD_NAT_RD);
    endfunction
endpackage

// File: rtl/auxch_databuf.sv
module auxch_databuf #(
    parameter int WORDS = 4,
    parameter int WW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [WW-1:0]       wr_data,
    input  logic                ld_en,
    input  logic [WORDS*WW-1:0] ld_data,
    output logic [WORDS*WW-1:0] flat
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                flat[w*WW +: WW] <= '0;
            else if (ld_en)
                flat[w*WW +: WW] <= ld_data[w*WW +: WW];
            else if (wr_en && (wr_idx == IW'(w)))
                flat[w*WW +: WW] <= wr_data;
        end
    end
endmodule

// File: rtl/auxch_irq.sv
module auxch_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         en_we,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~(clr_we ? clr_mask : '0)) | set_ev;
            if (en_we) en <= en_data;
        end
    end

    assign irq = |(pend & en);
endmodule

// File: rtl/auxch_regfront.sv
module auxch_regfront
    import auxch_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BUS_AW = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic                        eng_start,
    output logic [2:0]                  eng_cmd,
    output logic                        eng_addr_only,
    output logic [ADDR_W-1:0]           eng_addr,
    output logic [CNT_W-1:0]            eng_len,
    output logic [BUF_WORDS*WORD_W-1:0] eng_txdata,
    input  logic                        eng_done,
    input  logic [2:0]                  eng_reply,
    input  logic [CNT_W-1:0]            eng_rxcnt,
    input  logic [ERR_W-1:0]            eng_err,
    input  logic [BUF_WORDS*WORD_W-1:0] eng_rxdata,
    input  logic                        hpd,
    input  logic                        sink_irq,
    output logic                        irq_o
);
    localparam int IDX_W = BUS_AW - 2;

    logic [IDX_W-1:0]  idx;
    logic [WIDX_W-1:0] widx;
    logic              wr, wr_ctrl, wr_stat, wr_tx, rd_tx, rd_rx, busy, done_ev, rx_take;
    ctrl_t             ctrl_q;
    logic              start_q, hpd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        rpl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ERR_W-1:0]  err_q;
    logic [NUM_IRQ-1:0] irq_set, irq_pend, irq_en;
    logic [BUF_WORDS*WORD_W-1:0] rx_flat;

    assign idx     = bus_addr[BUS_AW-1:2];
    assign widx    = idx[WIDX_W-1:0];
    assign wr      = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
    assign busy    = ctrl_q.go;
    assign wr_ctrl = wr && (idx == IDX_W'(IDX_CTRL)) && !busy;
    assign wr_stat = wr && (idx == IDX_W'(IDX_STAT));
    assign rd_tx   = idx[IDX_W-1:WIDX_W] == (IDX_W-WIDX_W)'(IDX_TX0 / BUF_WORDS);
    assign rd_rx   = idx[IDX_W-1:WIDX_W] == (IDX_W-WIDX_W)'(IDX_RX0 / BUF_WORDS);
    assign wr_tx   = wr && rd_tx && !busy;
    assign done_ev = busy && eng_done;
    assign rx_take = done_ev && cmd_is_read(ctrl_q.cmd) && (eng_reply == RPL_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= 1'b0;
            addr_q  <= '0;
            rpl_q   <= '0;
            cnt_q   <= '0;
            err_q   <= '0;
            hpd_q   <= 1'b0;
        end else begin
            hpd_q   <= hpd;
            start_q <= wr_ctrl && bus_wdata[CTRL_GO_BIT];
            if (wr && (idx == IDX_W'(IDX_ADDR)))
                addr_q <= bus_wdata[ADDR_W-1:0];
            if (wr_ctrl) begin
                ctrl_q.len_m1    <= bus_wdata[LEN_W-1:0];
                ctrl_q.addr_only <= bus_wdata[CTRL_AO_BIT];
                ctrl_q.cmd       <= aux_cmd_e'(bus_wdata[CTRL_CMD_LSB +: 3]);
                ctrl_q.go        <= bus_wdata[CTRL_GO_BIT];
            end else if (done_ev) begin
                ctrl_q.go <= 1'b0;
            end
            err_q <= (err_q & ~(wr_stat ? bus_wdata[STAT_ERR_LSB +: ERR_W] : '0))
                   | (done_ev ? eng_err : '0);
            if (done_ev) begin
                rpl_q <= eng_reply;
                cnt_q <= rx_take ? eng_rxcnt : '0;
            end
        end
    end

    auxch_databuf #(.WORDS(BUF_WORDS), .WW(WORD_W)) u_txbuf (
        .clk(clk), .rst(rst), .wr_en(wr_tx), .wr_idx(widx), .wr_data(bus_wdata),
        .ld_en(1'b0), .ld_data('0), .flat(eng_txdata)
    );

    auxch_databuf #(.WORDS(BUF_WORDS), .WW(WORD_W)) u_rxbuf (
        .clk(clk), .rst(rst), .wr_en(1'b0), .wr_idx('0), .wr_data('0),
        .ld_en(rx_take), .ld_data(eng_rxdata), .flat(rx_flat)
    );

    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_DONE]   = done_ev;
        irq_set[IRQ_SINK]   = sink_irq;
        irq_set[IRQ_UNPLUG] = hpd_q && !hpd;
        irq_set[IRQ_PLUG]   = hpd && !hpd_q;
    end

    auxch_irq #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst(rst), .set_ev(irq_set),
        .clr_we(wr && (idx == IDX_W'(IDX_IPEND))), .clr_mask(bus_wdata[NUM_IRQ-1:0]),
        .en_we(wr && (idx == IDX_W'(IDX_IEN))), .en_data(bus_wdata[NUM_IRQ-1:0]),
        .pend(irq_pend), .en(irq_en), .irq(irq_o)
    );

    assign eng_start     = start_q;
    assign eng_cmd       = ctrl_q.cmd;
    assign eng_addr_only = ctrl_q.addr_only;
    assign eng_addr      = addr_q;
    assign eng_len       = ctrl_q.addr_only ? '0 : ({1'b0, ctrl_q.len_m1} + CNT_W'(1));

    always_comb begin
        bus_rdata = '0;
        if (rd_tx)
            bus_rdata = eng_txdata[widx*WORD_W +: WORD_W];
        else if (rd_rx)
            bus_rdata = rx_flat[widx*WORD_W +: WORD_W];
        else begin
            case (idx)
                IDX_W'(IDX_ADDR): bus_rdata[ADDR_W-1:0] = addr_q;
                IDX_W'(IDX_CTRL): begin
                    bus_rdata[LEN_W-1:0]          = ctrl_q.len_m1;
                    bus_rdata[CTRL_AO_BIT]        = ctrl_q.addr_only;
                    bus_rdata[CTRL_CMD_LSB +: 3]  = ctrl_q.cmd;
                    bus_rdata[CTRL_GO_BIT]        = ctrl_q.go;
                end
                IDX_W'(IDX_STAT): begin
                    bus_rdata[CNT_W-1:0]             = cnt_q;
                    bus_rdata[STAT_ERR_LSB +: ERR_W] = err_q;
                    bus_rdata[STAT_RPL_LSB +: 3]     = rpl_q;
                    bus_rdata[STAT_HPD_BIT]          = hpd;
                end
                IDX_W'(IDX_IEN):   bus_rdata[NUM_IRQ-1:0] = irq_en;
                IDX_W'(IDX_IPEND): bus_rdata[NUM_IRQ-1:0] = irq_pend;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/auxch_regfront_chk.sv
module auxch_regfront_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       eng_start,
    input logic       eng_done,
    input logic       hpd,
    input logic [3:0] pend,
    input logic [3:0] err,
    input logic       stat_clr
);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    assert_go_held_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> busy);

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done) |=> (!busy && pend[0]));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((err & $past(err)) == $past(err)));

    assert_plug_pend_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(hpd) |=> pend[3]);
endmodule

bind auxch_regfront auxch_regfront_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .eng_start(eng_start), .eng_done(eng_done),
    .hpd(hpd), .pend(irq_pend), .err(err_q), .stat_clr(wr_stat)
);

// File: tb/auxch_regfront_test.sv
`timescale 1ns/1ps
module auxch_regfront_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_start, eng_addr_only;
    logic [2:0]   eng_cmd;
    logic [19:0]  eng_addr;
    logic [4:0]   eng_len;
    logic [127:0] eng_txdata;
    logic         eng_done = 1'b0;
    logic [2:0]   eng_reply = '0;
    logic [4:0]   eng_rxcnt = '0;
    logic [3:0]   eng_err = '0;
    logic [127:0] eng_rxdata = '0;
    logic         hpd = 1'b0, sink_irq = 1'b0;
    logic         irq_o;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    auxch_regfront uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .eng_addr_only(eng_addr_only), .eng_addr(eng_addr),
        .eng_len(eng_len), .eng_txdata(eng_txdata), .eng_done(eng_done),
        .eng_reply(eng_reply), .eng_rxcnt(eng_rxcnt), .eng_err(eng_err),
        .eng_rxdata(eng_rxdata), .hpd(hpd), .sink_irq(sink_irq), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(int idx);
        @(negedge clk);
        bus_addr = 6'(idx * 4);
        #1 rv = bus_rdata;
    endtask

    task automatic finish_xfer(logic [2:0] rpl, logic [4:0] cnt, logic [3:0] er, logic [127:0] data);
        @(negedge clk);
        eng_done = 1'b1; eng_reply = rpl; eng_rxcnt = cnt; eng_err = er; eng_rxdata = data;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(int len_m1, bit ao, int cmd, bit go);
        return 32'(len_m1) | (32'(ao) << 8) | (32'(cmd) << 12) | (32'(go) << 16);
    endfunction

    task automatic t_reset;
        for (int i = 0; i < 5; i++) begin
            rd(i);
            chk("R1 register reset", rv, 0);
        end
        chk("R1 irq_o reset", irq_o, 0);
        chk("R1 eng_start reset", eng_start, 0);
    endtask

    task automatic t_map;
        wr(0, 32'hF2345);
        rd(0);
        chk("R2 address readback", rv, 32'hF2345);
        for (int w = 0; w < 4; w++)
            wr(8 + w, {8'(16 + 4*w + 3), 8'(16 + 4*w + 2), 8'(16 + 4*w + 1), 8'(16 + 4*w)});
        rd(9);
        chk("R2 tx word1 readback", rv, 32'h17161514);
        for (int n = 0; n < 16; n += 5)
            chk("R3 tx byte lane", eng_txdata[8*n +: 8], 8'(16 + n));
        chk("R3 tx byte 15", eng_txdata[127:120], 8'h1F);
        wr(3, 32'h0);
        rd(3);
        chk("R2 enable readback", rv, 0);
    endtask

    task automatic t_write_xfer;
        wr(1, ctrl_word(5, 0, 3, 1));
        #1;
        chk("R4 start high", eng_start, 1);
        chk("R4 cmd native write", eng_cmd, 3);
        chk("R3 len is field+1", eng_len, 6);
        chk("R4 addr presented", eng_addr, 20'hF2345);
        chk("R3 addr_only low", eng_addr_only, 0);
        @(negedge clk); #1;
        chk("R4 start one cycle", eng_start, 0);
        rd(1);
        chk("R5 go reads busy", rv, ctrl_word(5, 0, 3, 1));
        wr(1, ctrl_word(2, 0, 1, 0));
        wr(8, 32'hDEADBEEF);
        rd(1);
        chk("R6 ctrl write ignored", rv, ctrl_word(5, 0, 3, 1));
        rd(8);
        chk("R6 tx write ignored", rv, 32'h13121110);
        finish_xfer(3'd0, 5'd7, 4'd0, {4{32'hCAFE0001}});
        rd(1);
        chk("R5 go cleared on done", rv, ctrl_word(5, 0, 3, 0));
        rd(2);
        chk("R7 write cmd count zero", rv, 0);
        rd(12);
        chk("R7 rx kept on write", rv, 0);
        rd(4);
        chk("R10 done pending", rv, 1);
        chk("R11 irq masked", irq_o, 0);
    endtask

    task automatic t_read_xfer;
        wr(4, 32'hF);
        wr(3, 32'h1);
        chk("R11 irq low after clear", irq_o, 0);
        wr(1, ctrl_word(15, 0, 5, 1));
        #1;
        chk("R3 max len 16", eng_len, 16);
        chk("R4 cmd mot read", eng_cmd, 5);
        finish_xfer(3'd0, 5'd16, 4'd0, 128'h0f0e0d0c_0b0a0908_07060504_03020100);
        #1;
        chk("R11 irq on done", irq_o, 1);
        rd(2);
        chk("R7 ack read count", rv, 32'd16);
        rd(13);
        chk("R7 rx word1", rv, 32'h07060504);
        rd(15);
        chk("R7 rx word3", rv, 32'h0f0e0d0c);
        wr(4, 32'h1);
        #1;
        chk("R11 irq cleared", irq_o, 0);
    endtask

    task automatic t_errors;
        wr(1, ctrl_word(0, 1, 0, 1));
        #1;
        chk("R3 address-only len", eng_len, 0);
        chk("R3 address-only flag", eng_addr_only, 1);
        finish_xfer(3'd4, 5'd0, 4'b0101, '0);
        rd(2);
        chk("R7 i2c nack reply", rv, (32'd4 << 16) | (32'h5 << 8));
        wr(1, ctrl_word(3, 0, 1, 1));
        finish_xfer(3'd2, 5'd3, 4'b1000, {4{32'h11111111}});
        rd(2);
        chk("R8 errors accumulate, R7 defer no count", rv, (32'd2 << 16) | (32'hD << 8));
        rd(12);
        chk("R7 rx kept on defer", rv, 32'h03020100);
        wr(2, 32'h100);
        rd(2);
        chk("R8 masked clear bit8", rv[11:8], 4'hC);
        wr(2, 32'h0);
        rd(2);
        chk("R8 zero write no effect", rv[11:8], 4'hC);
        wr(2, 32'hF00);
        rd(2);
        chk("R8 full clear", rv[11:8], 4'h0);
    endtask

    task automatic t_hotplug;
        wr(4, 32'hF);
        @(negedge clk); hpd = 1'b1;
        rd(2);
        chk("R9 hpd live", rv[28], 1);
        rd(4);
        chk("R10 plug pending", rv, 32'h8);
        @(negedge clk); hpd = 1'b0;
        rd(4);
        chk("R10 unplug pending", rv, 32'hC);
        rd(2);
        chk("R9 hpd low", rv[28], 0);
        @(negedge clk);
        sink_irq = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(4 * 4); bus_wdata = 32'h2;
        @(negedge clk);
        sink_irq = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(4);
        chk("R10 set beats clear", rv, 32'hE);
        wr(3, 32'h4);
        #1;
        chk("R11 unplug enabled irq", irq_o, 1);
        wr(4, 32'h4);
        #1;
        chk("R11 irq drops after clear", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_map;
        t_write_xfer;
        t_read_xfer;
        t_errors;
        t_hotplug;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule